// File: doc/BRIEF.md
# Wake-Pin Interrupt Controller

This block watches up to four external wake pins and three on-chip peripheral event lines (real-time clock, infrared receiver, watchdog). Each pin is brought into the clock domain by a two-flop synchroniser. A per-pin detector then looks for a programmable condition: a level, an edge, or any change. A detected condition sets a bit in a shared latched status word. Software masks the status word with an enable word and acknowledges it by writing ones to a clear word.

A single routing word chooses the sources that drive interrupts and the sources that can request a wake-up. The low half of the routing word holds the interrupt routes. The wake routes sit sixteen bits higher. The masked, routed pin status is OR-ed into one combined interrupt line. Each peripheral line is forwarded on its own output when routed. Software reaches every register through a plain single-cycle read/write port: writes take effect at the clock edge, and reads are combinational.

Top module: `wake_pin_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status (0x310), enable (0x314) and routing (0x31C) words read zero. Every pin's mode field reads 4, so a pin's configuration word reads 0x8 while the pin is low. All outputs are low.
- R2: Each pin passes through two synchronising flops. Bit 0 of pin n's configuration word (0x330 + 8*n) shows the synchronised pin value two edges after the pin changes. The companion word at 0x334 + 8*n reads zero, and writes to it are ignored.
- R3: Mode codes sit in configuration bits [3:1]. In mode 0 (level low) and mode 1 (level high), the status bit is set while the level condition holds. A clear write in these modes drops the bit for one cycle, and the bit is set again on the next edge if the condition still holds. Once the condition is gone, a clear leaves the bit at zero.
- R4: In mode 2 (falling), mode 3 (rising) and mode 6 (either edge), a detected edge sets the status bit. The bit stays set until a 1 is written to bit n of the clear word (0x318). An edge detected in the same cycle as that clear write is kept.
- R5: Mode 4, and the unused codes 5 and 7, never set the status bit, whatever the pin does.
- R6: pin_irq_o is high exactly when some pin n has status bit n, enable bit n and routing bit 8+n all set.
- R7: periph_irq_o[k] equals periph_evt_i[k] AND routing bit k. Here k=0 is the real-time clock, k=1 infrared and k=2 watchdog.
- R8: wake_req_o is high when some pin's status bit is set together with its routing bit 24+n, or when some peripheral line is high together with its routing bit 16+k. The enable word does not gate it.
- R9: Configuration bit 4 holds its pin's detector in reset. The status bit is cleared on the next edge and stays zero while the bit is set, and the mode field keeps its value.
- R10: Writes to the status word are ignored. Only bits [3:0] of the enable word are implemented. The routing word implements bits 0-2, 8-11, 16-18 and 24-27, and all other bits read zero. Configuration bits [4:1] are writable and bit 0 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| wake_pin_i | input | 4 | Asynchronous external wake pins |
| periph_evt_i | input | 3 | Peripheral events: [0] clock, [1] infrared, [2] watchdog |
| pin_irq_o | output | 1 | Combined wake-pin interrupt |
| periph_irq_o | output | 3 | Routed peripheral interrupts |
| wake_req_o | output | 1 | Wake request |

## Verification
The assertions check several rules on every cycle:
- A status bit stays set unless it is cleared or held.
- A held pin has zero status on the next cycle.
- A pin in mode 4 never raises its status bit.
- The interrupt and wake outputs only rise when an enable or route permits them.
- The first synchroniser flop follows the pin.

Only the bench's scenarios can show the rest:
- the two-edge synchroniser latency seen at the configuration readback;
- the one-cycle drop and re-assertion of a level status after a clear;
- an edge kept when it coincides with its clear;
- the exact routing of each source to each output;
- the masks applied to writes of unimplemented bits.

// File: rtl/wpic_pkg.sv
// Shared constants for the wake-pin interrupt controller.
// Assumes a byte-addressed register port with 32-bit words.
package wpic_pkg;

    localparam int STATUS_OFS = 'h310;
    localparam int ENABLE_OFS = 'h314;
    localparam int CLEAR_OFS  = 'h318;
    localparam int ROUTE_OFS  = 'h31C;
    localparam int CFG_BASE   = 'h330;
    localparam int CFG_STRIDE = 8;

    localparam int NUM_PERIPH   = 3;
    localparam int PIN_IRQ_BIT  = 8;
    localparam int PER_IRQ_BIT  = 0;
    localparam int WAKE_SHIFT   = 16;

    localparam logic [2:0] MODE_LEVEL_LO = 3'd0;
    localparam logic [2:0] MODE_LEVEL_HI = 3'd1;
    localparam logic [2:0] MODE_FALL     = 3'd2;
    localparam logic [2:0] MODE_RISE     = 3'd3;
    localparam logic [2:0] MODE_OFF      = 3'd4;
    localparam logic [2:0] MODE_ANY      = 3'd6;

    // Bits of the routing word that exist for a given pin count.
    function automatic logic [31:0] route_mask(input int pins);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < pins; i++) m[PIN_IRQ_BIT + i] = 1'b1;
        for (int k = 0; k < NUM_PERIPH; k++) m[PER_IRQ_BIT + k] = 1'b1;
        return m | (m << WAKE_SHIFT);
    endfunction

endpackage

// File: rtl/wpic_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous bits.
// Assumes each bit is a slow level; no multi-bit coherence is implied.
module wpic_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    // Shift the pin values through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

    assert_first_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stg_q[0] == $past(d_i));

endmodule

// File: rtl/wpic_pin_chan.sv
// One wake pin's detector and latched status bit.
// Assumes smp_i is already synchronised; edges compare against the previous sample.
module wpic_pin_chan
    import wpic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_i,
    input  logic [2:0] mode_i,
    input  logic       hold_i,
    input  logic       clr_i,
    output logic       status_o
);
    logic prev_q;
    logic rise, fall, lvl_hit, edge_hit;

    // Remember the last synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    // Decode the configured condition against the current sample.
    always_comb begin
        rise     = smp_i & ~prev_q;
        fall     = ~smp_i & prev_q;
        lvl_hit  = 1'b0;
        edge_hit = 1'b0;
        if (!hold_i) begin
            case (mode_i)
                MODE_LEVEL_LO: lvl_hit  = ~smp_i;
                MODE_LEVEL_HI: lvl_hit  = smp_i;
                MODE_FALL:     edge_hit = fall;
                MODE_RISE:     edge_hit = rise;
                MODE_ANY:      edge_hit = rise | fall;
                default: ;
            endcase
        end
    end

    // Latch events; a clear beats a level hit but never an edge hit.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) status_o <= 1'b0;
        else status_o <= edge_hit | (lvl_hit & ~clr_i) | (status_o & ~clr_i);
    end

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !clr_i && !hold_i) |=> status_o);

    assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !status_o);

    assert_off_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o && mode_i == MODE_OFF) |=> !status_o);

endmodule

// File: rtl/wake_pin_irq_ctrl.sv
// Wake-pin interrupt controller: register file, per-pin channels and output routing.
// Assumes a single-cycle register port (writes at the edge, combinational reads)
// and synchronous peripheral event lines.
module wake_pin_irq_ctrl
    import wpic_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   wake_pin_i,
    input  logic [NUM_PERIPH-1:0] periph_evt_i,
    output logic                  pin_irq_o,
    output logic [NUM_PERIPH-1:0] periph_irq_o,
    output logic                  wake_req_o
);
    localparam logic [31:0] ROUTE_MASK = route_mask(NUM_PINS);

    logic [NUM_PINS-1:0] smp, status, en_q, hold_q, clr_vec;
    logic [2:0]          mode_q [NUM_PINS];
    logic [31:0]         route_q;
    logic                wr_en, wr_route, wr_clr;

    wpic_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(wake_pin_i), .q_o(smp)
    );

    // Decode the write strobes for the shared words.
    always_comb begin
        wr_en    = bus_we && bus_addr == ADDR_W'(ENABLE_OFS);
        wr_route = bus_we && bus_addr == ADDR_W'(ROUTE_OFS);
        wr_clr   = bus_we && bus_addr == ADDR_W'(CLEAR_OFS);
        clr_vec  = wr_clr ? bus_wdata[NUM_PINS-1:0] : '0;
    end

    // Hold the enable and routing words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
        end else begin
            if (wr_en)    en_q    <= bus_wdata[NUM_PINS-1:0];
            if (wr_route) route_q <= bus_wdata & ROUTE_MASK;
        end
    end

    generate
        for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
            localparam int CFG_ADDR = CFG_BASE + CFG_STRIDE * n;

            // Hold this pin's mode and detector-hold controls.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mode_q[n] <= MODE_OFF;
                    hold_q[n] <= 1'b0;
                end else if (bus_we && bus_addr == ADDR_W'(CFG_ADDR)) begin
                    mode_q[n] <= bus_wdata[3:1];
                    hold_q[n] <= bus_wdata[4];
                end
            end

            wpic_pin_chan u_chan (
                .clk(clk), .rst_n(rst_n), .smp_i(smp[n]), .mode_i(mode_q[n]),
                .hold_i(hold_q[n]), .clr_i(clr_vec[n]), .status_o(status[n])
            );
        end
    endgenerate

    // Return the addressed register; unmapped and companion words read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(STATUS_OFS)) bus_rdata[NUM_PINS-1:0] = status;
        if (bus_addr == ADDR_W'(ENABLE_OFS)) bus_rdata[NUM_PINS-1:0] = en_q;
        if (bus_addr == ADDR_W'(ROUTE_OFS))  bus_rdata = route_q;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (bus_addr == ADDR_W'(CFG_BASE + CFG_STRIDE * n))
                bus_rdata[4:0] = {hold_q[n], mode_q[n], smp[n]};
        end
    end

    // Combine routed sources into the interrupt and wake outputs.
    always_comb begin
        pin_irq_o    = |(status & en_q & route_q[PIN_IRQ_BIT +: NUM_PINS]);
        periph_irq_o = periph_evt_i & route_q[PER_IRQ_BIT +: NUM_PERIPH];
        wake_req_o   = |(status & route_q[PIN_IRQ_BIT + WAKE_SHIFT +: NUM_PINS])
                     | |(periph_evt_i & route_q[PER_IRQ_BIT + WAKE_SHIFT +: NUM_PERIPH]);
    end

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_q == '0 && route_q == '0 && status == '0));

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_irq_o |-> (|en_q && |status));

    assert_wake_needs_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> |(route_q >> WAKE_SHIFT));

    assert_route_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q & ~ROUTE_MASK) == '0);

    generate
        for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_per_chk
            assert_periph_routed_R7: assert property (@(posedge clk) disable iff (!rst_n)
                periph_irq_o[k] |-> (route_q[k] && periph_evt_i[k]));
        end
    endgenerate

endmodule

// File: tb/wake_pin_irq_ctrl_bench.sv
`timescale 1ns/100ps
module wake_pin_irq_ctrl_bench;
    typedef struct {
        bit          is_out;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pins = '0;
    logic [2:0]  pevt = '0;
    logic        pin_irq, wake;
    logic [2:0]  pirq;

    int     n_cmp = 0, n_bad = 0;
    bit     done = 0;
    item_t  sbq[$];
    event   chk_ev;

    always #2 clk = ~clk;

    wake_pin_irq_ctrl u_wake_pin_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_pin_i(pins),
        .periph_evt_i(pevt), .pin_irq_o(pin_irq), .periph_irq_o(pirq),
        .wake_req_o(wake)
    );

    // Monitor: pop expected items and compare with what the design shows.
    initial forever begin
        @(chk_ev);
        while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = it.is_out ? {27'b0, pirq, wake, pin_irq} : bus_rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string r);
        item_t it;
        bus_addr = a;
        #0.2;
        it.is_out = 0; it.exp = e; it.req = r;
        sbq.push_back(it);
        ->chk_ev;
        #0.2;
    endtask

    // Expected outputs packed as {periph_irq[2:0], wake, pin_irq}.
    task automatic out_chk(input logic [4:0] e, input string r);
        item_t it;
        #0.2;
        it.is_out = 1; it.exp = {27'b0, e}; it.req = r;
        sbq.push_back(it);
        ->chk_ev;
        #0.2;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        rd_chk(12'h310, 32'h0, "R1 status");
        rd_chk(12'h314, 32'h0, "R1 enable");
        rd_chk(12'h31C, 32'h0, "R1 route");
        rd_chk(12'h330, 32'h8, "R1 cfg0 mode 4");
        out_chk(5'b0, "R1 outputs");

        // R10 register masks
        wr(12'h310, 32'hF);
        rd_chk(12'h310, 32'h0, "R10 status write ignored");
        wr(12'h31C, 32'hFFFF_FFFF);
        rd_chk(12'h31C, 32'h0F07_0F07, "R10 route mask");
        wr(12'h314, 32'hFFFF_FFFF);
        rd_chk(12'h314, 32'hF, "R10 enable mask");
        wr(12'h31C, 32'h0);
        wr(12'h314, 32'h0);

        // R2 synchroniser latency and companion slot; R5 mode 4 silent
        pins[2] = 1;
        idle(1);
        rd_chk(12'h340, 32'h8, "R2 one edge not yet visible");
        idle(1);
        rd_chk(12'h340, 32'h9, "R2 two edges visible");
        wr(12'h344, 32'hFF);
        rd_chk(12'h344, 32'h0, "R2 companion slot");
        pins[2] = 0; idle(4); pins[2] = 1; idle(4);
        wr(12'h348, 32'hE);
        idle(2);
        rd_chk(12'h310, 32'h0, "R5 modes 4 and 7 set nothing");
        wr(12'h348, 32'h8);

        // R3 level high on pin 1
        wr(12'h338, 32'h2);
        pins[1] = 1; idle(4);
        rd_chk(12'h310, 32'h2, "R3 level high set");
        wr(12'h318, 32'h2);
        rd_chk(12'h310, 32'h0, "R3 clear drops one cycle");
        idle(1);
        rd_chk(12'h310, 32'h2, "R3 level re-asserts");
        pins[1] = 0; idle(4);
        wr(12'h318, 32'h2); idle(2);
        rd_chk(12'h310, 32'h0, "R3 cleared after level gone");
        wr(12'h338, 32'h8);
        // R3 level low on pin 3
        wr(12'h348, 32'h0); pins[3] = 0; idle(2);
        rd_chk(12'h310, 32'h8, "R3 level low set");
        wr(12'h348, 32'h8); wr(12'h318, 32'h8); idle(1);
        rd_chk(12'h310, 32'h0, "R3 level low cleared");

        // R4 rising edge sticky on pin 0
        wr(12'h330, 32'h6);
        pins[0] = 1; idle(4);
        rd_chk(12'h310, 32'h1, "R4 rise set");
        pins[0] = 0; idle(4);
        rd_chk(12'h310, 32'h1, "R4 sticky");
        wr(12'h318, 32'h1);
        rd_chk(12'h310, 32'h0, "R4 clear");
        pins[0] = 1; idle(4); pins[0] = 0; idle(4);
        pins[0] = 1; idle(2);
        wr(12'h318, 32'h1);
        rd_chk(12'h310, 32'h1, "R4 edge during clear kept");
        idle(2);
        wr(12'h318, 32'h1);
        rd_chk(12'h310, 32'h0, "R4 clear after kept edge");
        // R4 either edge catches a fall
        wr(12'h330, 32'hC);
        pins[0] = 0; idle(4);
        rd_chk(12'h310, 32'h1, "R4 any-edge fall");

        // R6 combined interrupt
        wr(12'h31C, 32'h100);
        out_chk(5'b00000, "R6 no enable no irq");
        wr(12'h314, 32'h1);
        out_chk(5'b00001, "R6 irq on");
        wr(12'h314, 32'h0);

        // R8 and R7 wake and peripheral routing
        wr(12'h31C, 32'h0100_0000);
        out_chk(5'b00010, "R8 pin wake without enable");
        wr(12'h31C, 32'h0002_0002);
        out_chk(5'b00000, "R7 no event no output");
        pevt = 3'b010;
        out_chk(5'b01010, "R7 R8 infrared routed");
        pevt = 3'b101;
        out_chk(5'b00000, "R7 unrouted events blocked");
        pevt = 3'b000;
        wr(12'h31C, 32'h0);

        // R9 detector hold
        wr(12'h330, 32'h1C); idle(1);
        rd_chk(12'h310, 32'h0, "R9 hold clears status");
        pins[0] = 1; idle(4); pins[0] = 0; idle(4);
        rd_chk(12'h310, 32'h0, "R9 held pin ignores edges");
        rd_chk(12'h330, 32'h1C, "R9 mode kept under hold");
        wr(12'h330, 32'hC);
        pins[0] = 1; idle(4);
        rd_chk(12'h310, 32'h1, "R9 released pin detects");

        idle(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule